// File: doc/BRIEF.md
# Triangle base timer

This block is the free-running time base of an input-capture/output-compare unit. Once enabled it counts by one per clock. Instead of wrapping, it turns around at both ends of its range, so its value traces a triangle between 0000h and FFFFh. Capture and waveform channels elsewhere in the unit read the count value, the direction flag and a one-clock match strobe.

A compare value can shorten the triangle. When the reverse-on-match mode is on and the counter climbs past the compare value, it takes exactly two more upward steps and then starts counting down. The peak therefore sits at compare+2. The bottom turnaround at zero is unchanged. When the enable is low, the counter holds its value, its direction and any reversal that is still pending.

Top module: `tri_base_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `count_value` is 0000h, `count_down` is 0 and `match_pulse` is 0.
- R2: With `run_en` high, `count_value` changes by exactly one at each rising clock edge, in the current direction.
- R3: An upward count that reaches FFFFh turns on the next enabled step: FFFFh is followed by FFFEh, and `count_down` reads 1 from then on.
- R4: A downward count that reaches 0000h turns on the next enabled step: 0000h is followed by 0001h, and `count_down` reads 0.
- R5: With `run_en` low, the count, the direction and any pending reversal are held unchanged, and `match_pulse` stays 0. This holds even when the count equals `cmp_value` or when `cmp_value` is changed.
- R6: `match_pulse` is 1 for exactly one clock, in the cycle after an enabled step that lands the count on `cmp_value`. This applies in either direction.
- R7: With `rev_on_match` at 1, an upward step taken from a count equal to `cmp_value` arms a reversal. Two further upward steps follow, and then the count turns down. With compare value C the sequence is C, C+1, C+2, C+1.
- R8: If the count reaches FFFFh before an armed reversal fires, it turns at FFFFh, and the pending reversal is discarded.
- R9: With `rev_on_match` at 0, the compare value never alters the direction. Dropping `rev_on_match` while a reversal is armed cancels that reversal for good.
- R10: `count_down` is 1 when the most recent step was a decrement and 0 when it was an increment (0 after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Count enable; low freezes all state |
| rev_on_match | input | 1 | Enables the delayed reversal after a compare match |
| cmp_value | input | 16 | Compare value |
| count_value | output | 16 | Registered counter value |
| count_down | output | 1 | Direction of the last step, 1 = decrementing |
| match_pulse | output | 1 | One-clock strobe when the count lands on `cmp_value` |

## Verification
The bench drives the counter through a full climb and a full descent, so both turnaround points are exercised. A design that wrapped at either end, or that repeated the end value, would miscompare on the count right there. It arms a reversal at FFFEh so that the top limit and the pending reversal collide. A tracker that survived the turnaround would later reverse the count at the wrong place. Further directed segments check three things: the exact C, C+1, C+2, C+1 peak, where an off-by-one delay moves the peak; cancelling a reversal by dropping the mode, where a stale reversal would turn the count early; and freezing with an armed reversal and the count equal to the compare value, where a leaky freeze moves the count or emits a strobe. Seeded random enables, mode toggles and compare values placed near the count then mix all of these.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

  // Direction of the most recent counter step.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } tri_dir_e;

endpackage

// File: rtl/tri_step_unit.sv
// Combinational next-value logic: picks the direction of the coming step
// (limits first, then a forced reversal, else keep going) and applies it.
module tri_step_unit
  import tri_timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] cur_count,
  input  tri_dir_e         cur_dir,
  input  logic             force_rev,
  output logic [WIDTH-1:0] nxt_count,
  output tri_dir_e         nxt_dir,
  output logic             step_up
);

  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] BOT_VAL = '0;
  localparam logic [WIDTH-1:0] ONE_VAL = WIDTH'(1);

  logic at_top;
  logic at_bot;

  always_comb begin
    at_top = (cur_count == TOP_VAL);
    at_bot = (cur_count == BOT_VAL);
    if (at_bot) begin
      step_up = 1'b1;
    end else if (at_top) begin
      step_up = 1'b0;
    end else if (force_rev) begin
      step_up = 1'b0;
    end else begin
      step_up = (cur_dir == DIR_UP);
    end
    nxt_count = step_up ? (cur_count + ONE_VAL) : (cur_count - ONE_VAL);
    nxt_dir   = step_up ? DIR_UP : DIR_DOWN;
  end

endmodule

// File: rtl/tri_rev_delay.sv
// Tracks a reversal armed by an upward step out of the compare value and
// releases it after REV_DELAY further upward steps.
module tri_rev_delay #(
  parameter int REV_DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic mode_en,
  input  logic up_step,
  input  logic at_cmp,
  output logic force_rev
);

  localparam int REM_W = (REV_DELAY > 2) ? $clog2(REV_DELAY) : 1;

  logic armed_q;

  generate
    if (REV_DELAY == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          armed_q <= 1'b0;
        end else if (step) begin
          if (!mode_en) begin
            armed_q <= 1'b0;
          end else if (armed_q) begin
            armed_q <= up_step;
          end else if (up_step && at_cmp) begin
            armed_q <= 1'b1;
          end
        end
      end
      assign force_rev = mode_en & armed_q;
    end else begin : g_multi
      localparam logic [REM_W-1:0] REM_INIT = REM_W'(REV_DELAY - 1);
      logic [REM_W-1:0] rem_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          armed_q <= 1'b0;
          rem_q   <= '0;
        end else if (step) begin
          if (!mode_en) begin
            armed_q <= 1'b0;
          end else if (armed_q) begin
            if (!up_step) begin
              armed_q <= 1'b0;
            end else begin
              rem_q <= rem_q - 1'b1;
            end
          end else if (up_step && at_cmp) begin
            armed_q <= 1'b1;
            rem_q   <= REM_INIT;
          end
        end
      end
      assign force_rev = mode_en & armed_q & (rem_q == '0);
    end
  endgenerate

endmodule

// File: rtl/tri_match_reg.sv
// Registered compare strobe: fires for the cycle in which the count has just
// stepped onto the compare value.
module tri_match_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [WIDTH-1:0] nxt_count,
  input  logic [WIDTH-1:0] cmp_value,
  output logic             pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
    end else begin
      pulse <= step && (nxt_count == cmp_value);
    end
  end

endmodule

// File: rtl/tri_base_timer.sv
module tri_base_timer
  import tri_timer_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int REV_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             rev_on_match,
  input  logic [WIDTH-1:0] cmp_value,
  output logic [WIDTH-1:0] count_value,
  output logic             count_down,
  output logic             match_pulse
);

  logic [WIDTH-1:0] count_q;
  tri_dir_e         dir_q;
  logic [WIDTH-1:0] nxt_count;
  tri_dir_e         nxt_dir;
  logic             step_up;
  logic             force_rev;
  logic             at_cmp;

  assign at_cmp = (count_q == cmp_value);

  tri_step_unit #(.WIDTH(WIDTH)) u_step (
    .cur_count (count_q),
    .cur_dir   (dir_q),
    .force_rev (force_rev),
    .nxt_count (nxt_count),
    .nxt_dir   (nxt_dir),
    .step_up   (step_up)
  );

  tri_rev_delay #(.REV_DELAY(REV_DELAY)) u_rev (
    .clk       (clk),
    .rst       (rst),
    .step      (run_en),
    .mode_en   (rev_on_match),
    .up_step   (step_up),
    .at_cmp    (at_cmp),
    .force_rev (force_rev)
  );

  tri_match_reg #(.WIDTH(WIDTH)) u_match (
    .clk       (clk),
    .rst       (rst),
    .step      (run_en),
    .nxt_count (nxt_count),
    .cmp_value (cmp_value),
    .pulse     (match_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      dir_q   <= DIR_UP;
    end else if (run_en) begin
      count_q <= nxt_count;
      dir_q   <= nxt_dir;
    end
  end

  assign count_value = count_q;
  assign count_down  = (dir_q == DIR_DOWN);

endmodule

// File: rtl/tri_base_timer_chk.sv
module tri_base_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             rev_on_match,
  input logic [WIDTH-1:0] cmp_value,
  input logic [WIDTH-1:0] count_value,
  input logic             count_down,
  input logic             match_pulse
);

  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] ONE_VAL = WIDTH'(1);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count_value == '0) && !count_down && !match_pulse);

  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    run_en |=> (count_value == WIDTH'($past(count_value) + ONE_VAL)) ||
               (count_value == WIDTH'($past(count_value) - ONE_VAL)));

  assert_top_turn_R3: assert property (@(posedge clk) disable iff (rst)
    (run_en && count_value == TOP_VAL) |=>
      count_down && (count_value == WIDTH'(TOP_VAL - ONE_VAL)));

  assert_bottom_turn_R4: assert property (@(posedge clk) disable iff (rst)
    (run_en && count_value == '0) |=> !count_down && (count_value == ONE_VAL));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(count_value) && $stable(count_down) && !match_pulse);

  assert_pulse_value_R6: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> (count_value == $past(cmp_value)) && $past(run_en));

  assert_hold_dir_R9: assert property (@(posedge clk) disable iff (rst)
    (run_en && !rev_on_match && !count_down && count_value != TOP_VAL) |=> !count_down);

endmodule

bind tri_base_timer tri_base_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .run_en       (run_en),
  .rev_on_match (rev_on_match),
  .cmp_value    (cmp_value),
  .count_value  (count_value),
  .count_down   (count_down),
  .match_pulse  (match_pulse)
);

// File: tb/tb_tri_base_timer.sv
`timescale 1ns/1ps
module tb_tri_base_timer;

  localparam int W = 16;
  localparam logic [W-1:0] TOP = '1;

  logic         clk = 1'b0;
  logic         rst;
  logic         run_en;
  logic         rev_on_match;
  logic [W-1:0] cmp_value;
  logic [W-1:0] count_value;
  logic         count_down;
  logic         match_pulse;

  always #2 clk = ~clk;

  tri_base_timer #(.WIDTH(W), .REV_DELAY(2)) dut (
    .clk          (clk),
    .rst          (rst),
    .run_en       (run_en),
    .rev_on_match (rev_on_match),
    .cmp_value    (cmp_value),
    .count_value  (count_value),
    .count_down   (count_down),
    .match_pulse  (match_pulse)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // Reference model state, derived from the requirements
  logic [W-1:0] m_cnt;
  logic         m_up;
  logic         m_armed;
  int           m_rem;
  logic         m_pulse;

  task automatic model_step(input logic r, input logic md, input logic [W-1:0] c);
    logic up_now;
    logic [W-1:0] nxt;
    if (!r) begin
      m_pulse = 1'b0;
      return;
    end
    if (m_cnt == '0)                  up_now = 1'b1;   // R4
    else if (m_cnt == TOP)            up_now = 1'b0;   // R3
    else if (md && m_armed && m_rem == 0) up_now = 1'b0; // R7
    else                              up_now = m_up;
    if (!md) m_armed = 1'b0;                            // R9
    else if (m_armed) begin
      if (!up_now) m_armed = 1'b0;                      // R8
      else m_rem = m_rem - 1;
    end else if (up_now && m_cnt == c) begin
      m_armed = 1'b1;
      m_rem   = 1;
    end
    nxt = up_now ? W'(m_cnt + 1) : W'(m_cnt - 1);
    m_pulse = (nxt == c);                               // R6
    m_cnt   = nxt;
    m_up    = up_now;
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (count_value !== m_cnt) begin
      n_fails++;
      $display("FAIL %s count: actual %h expected %h", tag, count_value, m_cnt);
    end
    n_checks++;
    if (count_down !== !m_up) begin
      n_fails++;
      $display("FAIL %s direction (R10): actual %b expected %b", tag, count_down, !m_up);
    end
    n_checks++;
    if (match_pulse !== m_pulse) begin
      n_fails++;
      $display("FAIL %s match pulse (R6): actual %b expected %b", tag, match_pulse, m_pulse);
    end
  endtask

  task automatic cycle(input logic r, input logic md, input logic [W-1:0] c, input string tag);
    run_en       = r;
    rev_on_match = md;
    cmp_value    = c;
    model_step(r, md, c);
    @(negedge clk);
    check(tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R2 watchdog: actual run still active, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unused_seed;
    logic md_r;
    logic [W-1:0] cmp_r;
    unused_seed = $urandom(32'h1d5e);
    rst = 1'b1; run_en = 1'b1; rev_on_match = 1'b1; cmp_value = '0;
    m_cnt = '0; m_up = 1'b1; m_armed = 1'b0; m_rem = 0; m_pulse = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst = 1'b0;

    // R5: frozen at reset state while count equals compare: no strobe
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, '0, "R5");

    // R2: long climb with mode off (R9: passing compare does not reverse)
    while (m_cnt != 16'hFFE0) cycle(1'b1, 1'b0, 16'h0010, "R2/R9");

    // R3 with R8: reversal armed at FFFE collides with the top limit
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, 16'hFFFE, "R3/R8");

    // Long descent, then bottom turnaround with a downward match at 3
    while (m_cnt != 16'h0008) cycle(1'b1, 1'b0, 16'h0003, "R2");
    for (int i = 0; i < 12; i++) cycle(1'b1, 1'b0, 16'h0003, "R4");

    // R7: shortened triangle with peak at compare+2
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, 16'h0005, "R7");

    // R9: cancel an armed reversal by dropping the mode
    while (!(m_armed && m_cnt == 16'h0006)) cycle(1'b1, 1'b1, 16'h0005, "R7");
    cycle(1'b1, 1'b0, 16'h0005, "R9");
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, 16'h0005, "R9");

    // R5: freeze with a reversal armed, count equal to compare
    cmp_r = m_cnt;
    cycle(1'b1, 1'b1, cmp_r, "R5");
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, m_cnt, "R5");
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, cmp_r, "R5");

    // Seeded random mix
    md_r  = 1'b1;
    cmp_r = m_cnt;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 16 == 0) md_r = ~md_r;
      if ($urandom % 8 == 0) cmp_r = W'(m_cnt + W'($urandom % 5));
      cycle(($urandom % 5) != 0, md_r, cmp_r, "R2/R6/R7/R10");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule